// File: doc/BRIEF.md
# Stalled-Rotor Guard with Periodic Restart

This block protects a two-phase fan motor drive against a rotor that has stopped turning. It watches the already-conditioned Hall position state for changes and counts ticks of the drive PWM period. If the motor is running and the Hall state does not change for a full detect window, the block withdraws the enable from all motor drive outputs. It then holds them off for a retry window and re-enables them for another attempt. This cycle repeats for as long as the stall persists. Both windows are counted in PWM periods, so they stretch or shrink with the oscillator frequency. The defaults give about one second of detection and eight seconds of hold-off at a 22.7 kHz PWM rate.

A `run` input reflects the sleep/run decision made elsewhere. While it is low, the block sits in its sleep state with the drives off and both window counts cleared. The fault indicator follows open-drain convention. A low level means the motor is being driven normally. A high level means released: the block is in the stall hold-off or asleep.

The controller has three states. SLEEP is entered at reset and whenever `run` is low. WATCH drives the motor and times the detect window. LOCKOUT holds the drives off and times the retry window. The transitions are:
- wake: SLEEP to WATCH when `run` is high.
- stall: WATCH to LOCKOUT on the tick that completes the detect window.
- retry: LOCKOUT to WATCH on the tick that completes the retry window.
- doze: WATCH or LOCKOUT to SLEEP when `run` is low.

Top module: `rotor_stall_guard`

## Requirements
- R1: After reset, and while `run` stays low, `drive_en` is 0 and `stall_rel` is 1 (SLEEP).
- R2: With `run` high in SLEEP, the clock edge that samples it moves the block to WATCH, where `drive_en` is 1 and `stall_rel` is 0.
- R3: In WATCH, the clock edge that samples the DETECT_TICKS-th `pwm_tick` with no Hall change since entry or since the last change moves the block to LOCKOUT (`drive_en` 0, `stall_rel` 1). One tick fewer leaves it in WATCH.
- R4: Any change of `hall_state`, in either direction, while in WATCH restarts the detect count from zero.
- R5: A Hall change sampled on the same edge as the tick that would complete the detect window takes priority, and no lockout occurs.
- R6: LOCKOUT lasts exactly RETRY_TICKS ticks, after which the block returns to WATCH with a fresh detect count. Hall changes during LOCKOUT have no effect on its length.
- R7: If the rotor stays still after a retry, the detect and lockout sequence repeats without limit.
- R8: `run` low moves the block to SLEEP on the next edge from WATCH or LOCKOUT and clears both counts, so a later wake needs a full detect window before a lockout.
- R9: Clock edges without `pwm_tick` do not advance either window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_state | input | HALL_W | Conditioned rotor position state |
| pwm_tick | input | 1 | One-cycle pulse per PWM period |
| run | input | 1 | High = run, low = sleep |
| drive_en | output | 1 | Enable for all motor drive outputs |
| stall_rel | output | 1 | Fault indicator: 0 = pulled low (running), 1 = released |

## Verification
The assertions assume that `pwm_tick` is a single-cycle pulse and that `hall_state` and `run` are synchronous to `clk`, changing only between edges. The bench drives every input on the falling edge and raises each tick for exactly one cycle. It uses window lengths of 5 and 7 ticks, so that the window ends, the same-edge priority case and repeated retries all arise within a few hundred cycles. It inserts long tick-free stretches and toggles Hall in both directions, so that counting is seen to depend only on ticks and changes.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    typedef enum logic [1:0] {
        RSG_SLEEP   = 2'd0,
        RSG_WATCH   = 2'd1,
        RSG_LOCKOUT = 2'd2
    } rsg_state_e;

endpackage

// File: rtl/rsg_hall_change.sv
// Registers the Hall state and flags any bit that differs from the last sample.
module rsg_hall_change #(
    parameter int HALL_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALL_W-1:0] hall_in,
    output logic              changed
);

    logic [HALL_W-1:0] hall_q;
    logic [HALL_W-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hall_q <= '0;
        end else begin
            hall_q <= hall_in;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < HALL_W; gi++) begin : g_bit
            assign diff[gi] = hall_in[gi] ^ hall_q[gi];
        end
    endgenerate

    assign changed = |diff;

endmodule

// File: rtl/rsg_tick_window.sv
// Counts qualifying ticks up to LIMIT; flags the tick that completes the window
// and wraps to zero on it. A clear request wins over counting.
module rsg_tick_window #(
    parameter int LIMIT = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       adv,
    output logic [$clog2(LIMIT)-1:0]   count,
    output logic                       done
);

    localparam int W = $clog2(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign done  = adv && !clr && (cnt_q == LAST);
    assign count = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || done) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rsg_ctrl_fsm.sv
// Three-state controller: sleep, watch for rotation, locked-out hold-off.
module rsg_ctrl_fsm
    import rsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       det_done,
    input  logic       ret_done,
    output rsg_state_e state,
    output logic       drive_en,
    output logic       stall_rel
);

    rsg_state_e state_q;
    rsg_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSG_SLEEP: begin
                if (run) state_d = RSG_WATCH;            // wake
            end
            RSG_WATCH: begin
                if (!run)          state_d = RSG_SLEEP;  // doze
                else if (det_done) state_d = RSG_LOCKOUT;// stall
            end
            RSG_LOCKOUT: begin
                if (!run)          state_d = RSG_SLEEP;  // doze
                else if (ret_done) state_d = RSG_WATCH;  // retry
            end
            default: state_d = RSG_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSG_SLEEP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        drive_en  = 1'b0;
        stall_rel = 1'b1;
        unique case (state_q)
            RSG_WATCH: begin
                drive_en  = 1'b1;
                stall_rel = 1'b0;
            end
            RSG_SLEEP, RSG_LOCKOUT: begin
                drive_en  = 1'b0;
                stall_rel = 1'b1;
            end
            default: begin
                drive_en  = 1'b0;
                stall_rel = 1'b1;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/rotor_stall_guard.sv
module rotor_stall_guard
    import rsg_pkg::*;
#(
    parameter int HALL_W       = 1,
    parameter int DETECT_TICKS = 22700,
    parameter int RETRY_TICKS  = 181600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALL_W-1:0] hall_state,
    input  logic              pwm_tick,
    input  logic              run,
    output logic              drive_en,
    output logic              stall_rel
);

    localparam int DW = $clog2(DETECT_TICKS);
    localparam int RW = $clog2(RETRY_TICKS);

    rsg_state_e state;
    logic       hall_edge;
    logic       det_clr, ret_clr;
    logic       det_done, ret_done;
    logic [DW-1:0] det_cnt;
    logic [RW-1:0] ret_cnt;

    rsg_hall_change #(.HALL_W(HALL_W)) u_hall (
        .clk     (clk),
        .rst_n   (rst_n),
        .hall_in (hall_state),
        .changed (hall_edge)
    );

    assign det_clr = !run || hall_edge || (state != RSG_WATCH);
    assign ret_clr = !run || (state != RSG_LOCKOUT);

    rsg_tick_window #(.LIMIT(DETECT_TICKS)) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (det_clr),
        .adv   (pwm_tick),
        .count (det_cnt),
        .done  (det_done)
    );

    rsg_tick_window #(.LIMIT(RETRY_TICKS)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ret_clr),
        .adv   (pwm_tick),
        .count (ret_cnt),
        .done  (ret_done)
    );

    rsg_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .det_done  (det_done),
        .ret_done  (ret_done),
        .state     (state),
        .drive_en  (drive_en),
        .stall_rel (stall_rel)
    );

endmodule

// File: rtl/rotor_stall_guard_chk.sv
module rotor_stall_guard_chk
    import rsg_pkg::*;
#(
    parameter int DETECT_TICKS = 22700,
    parameter int RETRY_TICKS  = 181600
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             pwm_tick,
    input logic                             run,
    input logic                             hall_edge,
    input rsg_state_e                       state,
    input logic [$clog2(DETECT_TICKS)-1:0]  det_cnt,
    input logic [$clog2(RETRY_TICKS)-1:0]   ret_cnt,
    input logic                             drive_en,
    input logic                             stall_rel
);

    p_sleep_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RSG_SLEEP) |-> (!drive_en && stall_rel));

    p_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RSG_SLEEP && run) |=> (state == RSG_WATCH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        det_cnt < ($clog2(DETECT_TICKS))'(DETECT_TICKS - 1) || det_cnt == ($clog2(DETECT_TICKS))'(DETECT_TICKS - 1));

    p_edge_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RSG_WATCH && hall_edge) |=> (state != RSG_LOCKOUT));

    p_retry_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_cnt < ($clog2(RETRY_TICKS))'(RETRY_TICKS - 1) || ret_cnt == ($clog2(RETRY_TICKS))'(RETRY_TICKS - 1));

    p_lock_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RSG_LOCKOUT && run && !pwm_tick) |=> (state == RSG_LOCKOUT));

    p_doze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state == RSG_SLEEP && !drive_en && stall_rel));

    p_sleep_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RSG_SLEEP) |-> (det_cnt == '0 && ret_cnt == '0));

    p_tick_needed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RSG_WATCH && !pwm_tick) |=> (state != RSG_LOCKOUT));

endmodule

bind rotor_stall_guard rotor_stall_guard_chk #(
    .DETECT_TICKS (DETECT_TICKS),
    .RETRY_TICKS  (RETRY_TICKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_tick  (pwm_tick),
    .run       (run),
    .hall_edge (hall_edge),
    .state     (state),
    .det_cnt   (det_cnt),
    .ret_cnt   (ret_cnt),
    .drive_en  (drive_en),
    .stall_rel (stall_rel)
);

// File: tb/sim_rotor_stall_guard.sv
`timescale 1ns/1ps
module sim_rotor_stall_guard;

    localparam int DET = 5;
    localparam int RET = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [0:0] hall_state = 1'b0;
    logic pwm_tick = 1'b0;
    logic run = 1'b0;
    logic drive_en;
    logic stall_rel;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    rotor_stall_guard #(
        .HALL_W(1), .DETECT_TICKS(DET), .RETRY_TICKS(RET)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .hall_state(hall_state),
        .pwm_tick(pwm_tick), .run(run),
        .drive_en(drive_en), .stall_rel(stall_rel)
    );

    task automatic expect_out(input string req, input logic en, input logic rel);
        total++;
        if (drive_en !== en || stall_rel !== rel) begin
            bad++;
            $display("FAIL %s: drive_en=%b stall_rel=%b expected drive_en=%b stall_rel=%b",
                     req, drive_en, stall_rel, en, rel);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) pwm_tick = 1'b1;
            @(negedge clk) pwm_tick = 1'b0;
        end
    endtask

    task automatic flip_hall();
        @(negedge clk) hall_state = ~hall_state;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sleep one cycle, then wake: WATCH with cleared counts.
    task automatic fresh_watch();
        @(negedge clk) run = 1'b0;
        @(negedge clk) run = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        idle(3);
        expect_out("R1 in reset", 1'b0, 1'b1);
        @(negedge clk) rst_n = 1'b1;
        idle(4);
        expect_out("R1 after reset run low", 1'b0, 1'b1);
        ticks(DET + 1);
        expect_out("R1 ticks while asleep", 1'b0, 1'b1);
    endtask

    task automatic t_wake();
        @(negedge clk) run = 1'b1;
        @(negedge clk);
        expect_out("R2 wake", 1'b1, 1'b0);
    endtask

    task automatic t_lock();
        fresh_watch();
        ticks(DET - 1);
        expect_out("R3 one tick short", 1'b1, 1'b0);
        ticks(1);
        expect_out("R3 lockout", 1'b0, 1'b1);
    endtask

    task automatic t_restart();
        fresh_watch();
        ticks(DET - 2);
        flip_hall();
        ticks(DET - 1);
        expect_out("R4 rise restarts count", 1'b1, 1'b0);
        flip_hall();
        ticks(DET - 1);
        expect_out("R4 fall restarts count", 1'b1, 1'b0);
        ticks(1);
        expect_out("R4 lockout after full window", 1'b0, 1'b1);
    endtask

    task automatic t_same_edge();
        fresh_watch();
        ticks(DET - 1);
        @(negedge clk) begin pwm_tick = 1'b1; hall_state = ~hall_state; end
        @(negedge clk) pwm_tick = 1'b0;
        expect_out("R5 change beats final tick", 1'b1, 1'b0);
        ticks(DET - 1);
        expect_out("R5 count restarted", 1'b1, 1'b0);
        ticks(1);
        expect_out("R5 later lockout", 1'b0, 1'b1);
    endtask

    task automatic t_retry();
        fresh_watch();
        ticks(DET);
        expect_out("R6 in lockout", 1'b0, 1'b1);
        for (int i = 0; i < RET - 1; i++) begin
            ticks(1);
            flip_hall();
        end
        expect_out("R6 hall ignored, one tick short", 1'b0, 1'b1);
        ticks(1);
        expect_out("R6 retry re-enables", 1'b1, 1'b0);
        ticks(DET - 1);
        expect_out("R7 fresh detect window", 1'b1, 1'b0);
        ticks(1);
        expect_out("R7 second lockout", 1'b0, 1'b1);
        ticks(RET);
        expect_out("R7 second retry", 1'b1, 1'b0);
        ticks(DET);
        expect_out("R7 third lockout", 1'b0, 1'b1);
    endtask

    task automatic t_sleep();
        fresh_watch();
        ticks(DET - 1);
        @(negedge clk) run = 1'b0;
        @(negedge clk);
        expect_out("R8 doze from watch", 1'b0, 1'b1);
        @(negedge clk) run = 1'b1;
        @(negedge clk);
        ticks(DET - 1);
        expect_out("R8 detect count cleared", 1'b1, 1'b0);
        ticks(1);
        expect_out("R8 lockout after full window", 1'b0, 1'b1);
        ticks(RET - 1);
        @(negedge clk) run = 1'b0;
        @(negedge clk);
        expect_out("R8 doze from lockout", 1'b0, 1'b1);
        @(negedge clk) run = 1'b1;
        @(negedge clk);
        expect_out("R8 wake after lockout", 1'b1, 1'b0);
    endtask

    task automatic t_idle();
        fresh_watch();
        ticks(DET - 1);
        idle(60);
        expect_out("R9 no tick no advance", 1'b1, 1'b0);
        ticks(1);
        expect_out("R9 next tick completes window", 1'b0, 1'b1);
        idle(80);
        expect_out("R9 lockout waits for ticks", 1'b0, 1'b1);
        ticks(RET);
        expect_out("R9 retry after ticks", 1'b1, 1'b0);
    endtask

    initial begin
        t_reset();
        t_wake();
        t_lock();
        t_restart();
        t_same_edge();
        t_retry();
        t_sleep();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule